// File: doc/BRIEF.md
# 64-Source Vectored Interrupt Controller

This block collects 64 interrupt request lines and turns them into two processor interrupt outputs: a normal request (IRQ) and a fast request (FIQ). Each source has a byte-wide configuration register. The byte holds an enable, a choice between active-high level and rising or falling edge detection, and a destination code. Software configures the block and services it through a synchronous register port. The port has a byte address, 32-bit write data, a write enable, byte strobes and a combinational read data bus.

Edge events are captured in two 32-bit status words. Software clears a captured event by writing a one to its bit. For level sources, the status bit shows the live input, gated by the enable. A priority result register returns the number of the winning pending source that is routed to IRQ. When no such source is pending, the register reads 63, and software tells a real source 63 apart by bit 31 of the upper status word. The priority scan is either fixed or rotating. In rotating mode, a source that has been serviced becomes the lowest priority.

Top module: `intc_top`

## Requirements
- R1: After reset, every configuration byte reads 0 (disabled, level, routed to IRQ), both status words read 0 even with inputs high, the priority result (address 0x00, bits [5:0]) reads 63, both priority control words read 0, and irqOut and fiqOut are low.
- R2: The configuration byte of source n sits in the word at 0x40 + 4*(n/4), in byte lane n%4 (lane 0 is bits [7:0]). A write changes only the lanes whose busBe bit is set, and every written bit reads back.
- R3: In a configuration byte, bit 3 is the enable. When bits 5 and 6 are both 0, the source is active-high level: its status bit (0x80 bits for sources 0-31, 0x84 for sources 32-63) equals input AND enable, with no delay.
- R4: Configuration bit 5 selects rising-edge capture. A rising input edge sets the status bit on the next clock only if the source is enabled, and the bit stays set after the input falls. Writing 1 to a status bit clears it, writing 0 leaves it unchanged, and enabling a source whose input is already high captures nothing.
- R5: Configuration bit 6 selects falling-edge capture. Only a high-to-low input transition sets the status bit.
- R6: When a write-one clear and a new captured edge on the same source meet in the same clock, the status bit stays set.
- R7: Configuration bits [2:0] choose the destination: 0 drives irqOut, 1 drives fiqOut, and 2 to 7 drive neither output. Each output is high exactly when some enabled source with a set status bit is routed to it.
- R8: With fixed priority, the priority result is the lowest-numbered pending IRQ-routed source. It is 63 when none is pending.
- R9: Bit 6 of the IRQ priority control word (0x20) selects rotating priority. Once the last reported source stops pending, the scan restarts just above it, so that source becomes the lowest priority.
- R10: Sources routed to FIQ or to an auxiliary destination never appear in the priority result.
- R11: The IRQ (0x20) and FIQ (0x24) priority control words each store bit 6 and read it back in place. All their other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address of the register access (word aligned) |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write enable, acts on the rising clock edge |
| busBe | input | 4 | Byte strobes for the write |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| srcIn | input | 64 | Interrupt request lines, bit n is source n |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
The priority scan is driven with level sources that are all enabled, using single-source, multi-source, top-source-only and all-ones patterns. These patterns separate lowest-number selection from any other order, and they separate the idle code 63 from a real source 63 through status bit 31. Edge capture is driven with pulses on enabled and disabled sources, with falling-only transitions, and with a clear that coincides with a new edge, which separates set-over-clear from clear-over-set. A single source is moved through FIQ, auxiliary and IRQ destinations to show how routing reaches the outputs and the priority result. Two edge sources are then retriggered under rotating priority: a fixed scan would report 10, while the rotating scan must report 20.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int SRC_NUM    = 64;
  localparam int SRC_W      = $clog2(SRC_NUM);
  localparam int CFG_WORDS  = SRC_NUM / 4;
  localparam int CFG_WORD_W = $clog2(CFG_WORDS);
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;

  // configuration byte fields
  localparam int EN_BIT   = 3;
  localparam int RISE_BIT = 5;
  localparam int FALL_BIT = 6;
  localparam int DEST_W   = 3;
  // priority control word
  localparam int ROT_BIT  = 6;

  localparam logic [ADDR_W-1:0] A_PRIO   = 8'h00;
  localparam logic [ADDR_W-1:0] A_IRQPC  = 8'h20;
  localparam logic [ADDR_W-1:0] A_FIQPC  = 8'h24;
  localparam logic [ADDR_W-1:0] A_STS_LO = 8'h80;
  localparam logic [ADDR_W-1:0] A_STS_HI = 8'h84;

  typedef enum logic [2:0] {
    RD_NONE, RD_PRIO, RD_IRQPC, RD_FIQPC, RD_CFG, RD_STS_LO, RD_STS_HI
  } rdSel_e;

  typedef struct packed {
    logic                  cfgWe;
    logic [CFG_WORD_W-1:0] cfgWord;
    logic [3:0]            byteEn;
    logic                  stsLoWe;
    logic                  stsHiWe;
    logic                  irqPcWe;
    logic                  fiqPcWe;
    rdSel_e                rdSel;
  } busStrobe_t;
endpackage

// File: rtl/intc_bus_decode.sv
module intc_bus_decode
  import intc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [3:0]        be,
  output busStrobe_t        stb
);
  always_comb begin
    stb         = '0;
    stb.rdSel   = RD_NONE;
    stb.byteEn  = be;
    stb.cfgWord = addr[CFG_WORD_W+1:2];
    if (addr[7:6] == 2'b01 && addr[1:0] == 2'b00) begin
      stb.rdSel = RD_CFG;
      stb.cfgWe = we;
    end else begin
      case (addr)
        A_PRIO:   stb.rdSel = RD_PRIO;
        A_IRQPC:  begin stb.rdSel = RD_IRQPC;  stb.irqPcWe = we & be[0]; end
        A_FIQPC:  begin stb.rdSel = RD_FIQPC;  stb.fiqPcWe = we & be[0]; end
        A_STS_LO: begin stb.rdSel = RD_STS_LO; stb.stsLoWe = we; end
        A_STS_HI: begin stb.rdSel = RD_STS_HI; stb.stsHiWe = we; end
        default:  stb.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int NUM_SRC = SRC_NUM
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [DATA_W-1:0]  wdata,
  input  busStrobe_t         stb,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq,
  output logic               fiq,
  output logic [NUM_SRC-1:0] latchVec,
  output logic [NUM_SRC-1:0] enVec,
  output logic [NUM_SRC-1:0] edgeVec,
  output logic [NUM_SRC-1:0] evtVec,
  output logic [NUM_SRC-1:0] clrVec,
  output logic [NUM_SRC-1:0] irqPend,
  output logic [SRC_W-1:0]   prioNum,
  output logic               rotOn
);
  localparam int CFG_BITS = NUM_SRC * 8;

  logic [NUM_SRC-1:0]  srcPrev;
  logic [NUM_SRC-1:0]  stsVec;
  logic [NUM_SRC-1:0]  fiqPend;
  logic [CFG_BITS-1:0] cfgFlat;
  logic                fiqRot;

  // per-source configuration byte, edge detect and routing
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int W = s / 4;
    localparam int B = s % 4;
    logic [7:0] cfgByte;
    logic       cfgHit;
    logic       riseSel, fallSel;
    logic [DEST_W-1:0] dest;

    assign cfgHit = stb.cfgWe && (stb.cfgWord == CFG_WORD_W'(W)) && stb.byteEn[B];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfgByte <= '0;
      else if (cfgHit) cfgByte <= wdata[8*B +: 8];
    end

    assign cfgFlat[8*s +: 8] = cfgByte;
    assign enVec[s]   = cfgByte[EN_BIT];
    assign riseSel    = cfgByte[RISE_BIT];
    assign fallSel    = cfgByte[FALL_BIT];
    assign dest       = cfgByte[DEST_W-1:0];
    assign edgeVec[s] = riseSel | fallSel;
    assign evtVec[s]  = enVec[s] & ((riseSel & srcIn[s] & ~srcPrev[s]) |
                                    (fallSel & ~srcIn[s] & srcPrev[s]));
    assign stsVec[s]  = edgeVec[s] ? latchVec[s] : (srcIn[s] & enVec[s]);
    assign irqPend[s] = enVec[s] & stsVec[s] & (dest == DEST_W'(0));
    assign fiqPend[s] = enVec[s] & stsVec[s] & (dest == DEST_W'(1));
  end

  // write-one-to-clear masks, honouring byte strobes
  logic [DATA_W-1:0] beMask;
  assign beMask = {{8{stb.byteEn[3]}}, {8{stb.byteEn[2]}},
                   {8{stb.byteEn[1]}}, {8{stb.byteEn[0]}}};
  assign clrVec = {({DATA_W{stb.stsHiWe}} & beMask & wdata),
                   ({DATA_W{stb.stsLoWe}} & beMask & wdata)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcPrev  <= '0;
      latchVec <= '0;
    end else begin
      srcPrev  <= srcIn;
      latchVec <= ((latchVec & ~clrVec) | evtVec) & edgeVec;
    end
  end

  // priority control words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rotOn  <= 1'b0;
      fiqRot <= 1'b0;
    end else begin
      if (stb.irqPcWe) rotOn  <= wdata[ROT_BIT];
      if (stb.fiqPcWe) fiqRot <= wdata[ROT_BIT];
    end
  end

  // priority scan starting at effBase, wrapping
  logic [SRC_W-1:0] rotBase, effBase, winIdx, prevWin;
  logic             found, prevValid;

  assign effBase = rotOn ? rotBase : '0;

  always_comb begin
    logic [SRC_W-1:0] idx;
    found  = 1'b0;
    winIdx = '0;
    idx    = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      idx = SRC_W'(i) + effBase;
      if (irqPend[idx]) begin
        found  = 1'b1;
        winIdx = idx;
      end
    end
  end

  assign prioNum = found ? winIdx : SRC_W'(NUM_SRC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rotBase   <= '0;
      prevWin   <= '0;
      prevValid <= 1'b0;
    end else begin
      if (rotOn && prevValid && !irqPend[prevWin]) rotBase <= prevWin + SRC_W'(1);
      prevWin   <= winIdx;
      prevValid <= found;
    end
  end

  assign irq = |irqPend;
  assign fiq = |fiqPend;

  always_comb begin
    rdata = '0;
    case (stb.rdSel)
      RD_PRIO:   rdata = DATA_W'(prioNum);
      RD_IRQPC:  rdata[ROT_BIT] = rotOn;
      RD_FIQPC:  rdata[ROT_BIT] = fiqRot;
      RD_CFG:    rdata = cfgFlat[{stb.cfgWord, 5'd0} +: DATA_W];
      RD_STS_LO: rdata = stsVec[DATA_W-1:0];
      RD_STS_HI: rdata = stsVec[2*DATA_W-1:DATA_W];
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  input  logic [3:0]        busBe,
  output logic [DATA_W-1:0] busRdata,
  input  logic [SRC_NUM-1:0] srcIn,
  output logic              irqOut,
  output logic              fiqOut
);
  busStrobe_t         stb;
  logic [SRC_NUM-1:0] latchVec, enVec, edgeVec, evtVec, clrVec, irqPend;
  logic [SRC_W-1:0]   prioNum;
  logic               rotOn;

  intc_bus_decode u_dec (
    .addr(busAddr), .we(busWe), .be(busBe), .stb(stb)
  );

  intc_core #(.NUM_SRC(SRC_NUM)) u_core (
    .clk(clk), .rst_n(rst_n), .srcIn(srcIn), .wdata(busWdata), .stb(stb),
    .rdata(busRdata), .irq(irqOut), .fiq(fiqOut),
    .latchVec(latchVec), .enVec(enVec), .edgeVec(edgeVec), .evtVec(evtVec),
    .clrVec(clrVec), .irqPend(irqPend), .prioNum(prioNum), .rotOn(rotOn)
  );
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int NUM_SRC = SRC_NUM
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] latchVec,
  input logic [NUM_SRC-1:0] enVec,
  input logic [NUM_SRC-1:0] edgeVec,
  input logic [NUM_SRC-1:0] evtVec,
  input logic [NUM_SRC-1:0] clrVec,
  input logic [NUM_SRC-1:0] irqPend,
  input logic [SRC_W-1:0]   prioNum,
  input logic               rotOn
);
  p_idle_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irqOut |-> prioNum == SRC_W'(NUM_SRC - 1));

  p_winner_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> irqPend[prioNum]);

  p_fixed_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rotOn && irqOut) |->
      (irqPend & ((NUM_SRC'(1) << prioNum) - NUM_SRC'(1))) == '0);

  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clrVec & ~evtVec)) |=> (latchVec & $past(clrVec & ~evtVec)) == '0);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|evtVec) |=> (latchVec & $past(evtVec)) == ($past(evtVec) & edgeVec));

  p_no_capture_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (latchVec & ~$past(latchVec) & ~$past(enVec)) == '0);
endmodule

bind intc_top intc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .irqOut(irqOut), .latchVec(latchVec),
  .enVec(enVec), .edgeVec(edgeVec), .evtVec(evtVec), .clrVec(clrVec),
  .irqPend(irqPend), .prioNum(prioNum), .rotOn(rotOn)
);

// File: tb/tb_intc_top.sv
`timescale 1ns/1ps
module tb_intc_top;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic [3:0]  busBe = '0;
  logic [31:0] busRdata;
  logic [63:0] srcIn = '0;
  logic        irqOut, fiqOut;

  int nChk = 0;
  int nFail = 0;

  intc_top dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busBe(busBe), .busRdata(busRdata), .srcIn(srcIn),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  always #(CLK_NS/2) clk = ~clk;

  // {srcIn, expected priority, expected irq}; all sources enabled level IRQ
  localparam logic [70:0] VEC [8] = '{
    {64'h0000_0000_0000_0000, 6'd63, 1'b0},
    {64'h0000_0000_0000_0020, 6'd5,  1'b1},
    {64'h0000_0100_0000_0020, 6'd5,  1'b1},
    {64'h8000_0000_0000_0000, 6'd63, 1'b1},
    {64'h8000_0000_0000_0001, 6'd0,  1'b1},
    {64'h0000_0002_0000_0000, 6'd33, 1'b1},
    {64'hFFFF_FFFF_FFFF_FFFF, 6'd0,  1'b1},
    {64'hC000_0000_0000_0000, 6'd62, 1'b1}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    busAddr = a; busWdata = d; busBe = be; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    #2 d = busRdata;
  endtask

  task automatic cfgAll(input logic [31:0] v);
    for (int w = 0; w < 16; w++) wr(8'(8'h40 + 4*w), v, 4'hF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, d); check("R1 prio idle", d, 63);
    rd(8'h40, d); check("R1 cfg word 0", d, 0);
    rd(8'h7C, d); check("R1 cfg word 15", d, 0);
    rd(8'h20, d); check("R1 irq prio ctrl", d, 0);
    rd(8'h24, d); check("R1 fiq prio ctrl", d, 0);
    check("R1 outputs", {irqOut, fiqOut}, 0);
    srcIn[0] = 1'b1;
    rd(8'h80, d); check("R1 disabled source status", d, 0);
    check("R1 irq with disabled source", irqOut, 0);
    srcIn = '0;

    // R2 byte strobes
    wr(8'h44, 32'h1122_3344, 4'b0101);
    rd(8'h44, d); check("R2 strobed lanes", d, 32'h0022_0044);
    wr(8'h44, 32'h0, 4'hF);
    rd(8'h44, d); check("R2 cleared word", d, 0);

    // R8 / R3 table of level patterns
    cfgAll(32'h0808_0808);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk) srcIn = VEC[k][70:7];
      rd(8'h00, d); check("R8 priority pattern", d, 32'(VEC[k][6:1]));
      check("R8 irq pattern", irqOut, VEC[k][0]);
      rd(8'h80, d); check("R3 status lo follows input", d, VEC[k][38:7]);
      rd(8'h84, d); check("R3 status hi follows input", d, VEC[k][70:39]);
    end
    srcIn = 64'h20;
    wr(8'h44, 32'h0808_0008, 4'hF);  // disable source 5 only
    rd(8'h80, d); check("R3 level gated by enable", d, 0);
    check("R3 irq gated by enable", irqOut, 0);
    srcIn = '0;
    cfgAll(32'h0);

    // R4 rising edge on source 12
    wr(8'h4C, 32'h28, 4'b0001);
    @(negedge clk) srcIn[12] = 1'b1;
    @(negedge clk);
    rd(8'h80, d); check("R4 rise captured", d, 32'h1000);
    rd(8'h00, d); check("R4 rise priority", d, 12);
    srcIn[12] = 1'b0;
    rd(8'h80, d); check("R4 held after input low", d, 32'h1000);
    wr(8'h80, 32'h0, 4'hF);
    rd(8'h80, d); check("R4 write zero no effect", d, 32'h1000);
    wr(8'h80, 32'h1000, 4'hF);
    rd(8'h80, d); check("R4 write one clears", d, 0);
    check("R4 irq after clear", irqOut, 0);
    wr(8'h4C, 32'h20, 4'b0001);  // rise, disabled
    @(negedge clk) srcIn[12] = 1'b1;
    @(negedge clk);
    rd(8'h80, d); check("R4 disabled edge ignored", d, 0);
    wr(8'h4C, 32'h28, 4'b0001);  // enable with input high
    rd(8'h80, d); check("R4 enable with high input", d, 0);
    @(negedge clk) srcIn[12] = 1'b0;

    // R5 falling edge on source 40
    wr(8'h68, 32'h48, 4'b0001);
    @(negedge clk) srcIn[40] = 1'b1;
    @(negedge clk);
    rd(8'h84, d); check("R5 rise not captured", d, 0);
    srcIn[40] = 1'b0;
    @(negedge clk);
    rd(8'h84, d); check("R5 fall captured", d, 32'h100);
    rd(8'h00, d); check("R5 fall priority", d, 40);
    wr(8'h84, 32'h100, 4'hF);
    rd(8'h84, d); check("R5 cleared", d, 0);
    wr(8'h68, 32'h0, 4'b0001);

    // R6 clear and new edge in the same cycle (source 12)
    @(negedge clk) srcIn[12] = 1'b1;
    @(negedge clk) srcIn[12] = 1'b0;
    rd(8'h80, d); check("R6 pre-set", d, 32'h1000);
    @(negedge clk);
    srcIn[12] = 1'b1;
    busAddr = 8'h80; busWdata = 32'h1000; busBe = 4'hF; busWe = 1'b1;
    @(negedge clk) busWe = 1'b0;
    rd(8'h80, d); check("R6 set wins over clear", d, 32'h1000);
    wr(8'h80, 32'h1000, 4'hF);
    rd(8'h80, d); check("R6 plain clear", d, 0);
    srcIn[12] = 1'b0;
    wr(8'h4C, 32'h0, 4'b0001);

    // R7 / R10 routing of level source 3
    wr(8'h40, 32'h0900_0000, 4'b1000);
    @(negedge clk) srcIn[3] = 1'b1;
    #2;
    check("R7 fiq route outputs", {irqOut, fiqOut}, 2'b01);
    rd(8'h00, d); check("R10 fiq source not in priority", d, 63);
    wr(8'h40, 32'h0D00_0000, 4'b1000);
    #2;
    check("R7 aux route outputs", {irqOut, fiqOut}, 2'b00);
    rd(8'h80, d); check("R7 aux status", d, 32'h8);
    rd(8'h00, d); check("R10 aux source not in priority", d, 63);
    wr(8'h40, 32'h0800_0000, 4'b1000);
    #2;
    check("R7 irq route outputs", {irqOut, fiqOut}, 2'b10);
    rd(8'h00, d); check("R7 irq route priority", d, 3);
    srcIn[3] = 1'b0;
    wr(8'h40, 32'h0, 4'hF);

    // R11 priority control readback
    wr(8'h24, 32'hFFFF_FFFF, 4'hF);
    rd(8'h24, d); check("R11 fiq ctrl bit6", d, 32'h40);
    wr(8'h24, 32'h0, 4'hF);
    rd(8'h24, d); check("R11 fiq ctrl cleared", d, 0);
    wr(8'h20, 32'h40, 4'hF);
    rd(8'h20, d); check("R11 irq ctrl bit6", d, 32'h40);

    // R9 rotating priority with edge sources 10 and 20
    wr(8'h48, 32'h0028_0000, 4'b0100);
    wr(8'h54, 32'h28, 4'b0001);
    @(negedge clk) begin srcIn[10] = 1'b1; srcIn[20] = 1'b1; end
    @(negedge clk) begin srcIn[10] = 1'b0; srcIn[20] = 1'b0; end
    rd(8'h00, d); check("R9 first winner", d, 10);
    wr(8'h80, 32'h400, 4'hF);
    rd(8'h00, d); check("R9 next winner", d, 20);
    @(negedge clk) srcIn[10] = 1'b1;
    @(negedge clk) srcIn[10] = 1'b0;
    rd(8'h00, d); check("R9 serviced source lowest", d, 20);
    wr(8'h80, 32'h10_0000, 4'hF);
    rd(8'h00, d); check("R9 wrap to source 10", d, 10);
    wr(8'h80, 32'h400, 4'hF);
    rd(8'h00, d); check("R9 idle after clears", d, 63);

    summary();
    $finish;
  end
endmodule